// File: doc/BRIEF.md
# Ternary Match Table with Priority Result

This block is a small ternary content-addressable table. Every slot stores a data word, a don't-care word and an occupied flag, so each stored bit acts as 0, 1 or X. A search takes a key and the number of one of several global don't-care registers. All occupied slots are compared in parallel, and bits that are don't-care in either the slot or the chosen global register are skipped. The block returns the lowest-numbered matching slot, a hit flag, a completion strobe and a flag that says more than one slot matched.

A learn request copies the comparand register into the lowest unoccupied slot. That slot has no don't-care bits and is marked occupied. The block reports the chosen slot through the same result port, or reports that the table is full. Slots, global registers and the comparand register are loaded through simple one-cycle write ports. Results come out two cycles after the request, in request order, and a new request may be issued every cycle.

Top module: `tcam_lookup`

## Requirements
- R1: After reset no slot is occupied, every global don't-care register is zero, all result outputs are 0, and a search misses.
- R2: A slot bit whose don't-care bit is 1 matches either key value; a slot bit with don't-care 0 must equal the key bit.
- R3: For a search, a key bit is ignored when bit of the same position in the global register selected by `lk_gsel` is 1; other registers have no effect on that search.
- R4: When several slots match, `res_index` is the lowest matching slot number; slot 0 has the highest priority.
- R5: Every search gives `res_valid`=1 with `res_learn`=0; `res_hit` is 1 on a match and 0 on a miss, and on a miss `res_index` is 0.
- R6: `res_multi` is 1 for a search that matches two or more slots, and 0 otherwise.
- R7: A request sampled on clock edge k shows its result after edge k+2; back-to-back requests give results in request order, one per cycle.
- R8: A slot write (data, don't-care, occupied flag from `ent_wr_used`) is seen by a search issued in the next cycle; writing occupied=0 removes the slot from matching.
- R9: A learn writes the comparand into the lowest unoccupied slot with all don't-care bits 0 and marks it occupied. The result has `res_valid`=1, `res_learn`=1, `res_hit`=1 and `res_index` set to that slot. The new slot takes part in searches issued in the next cycle.
- R10: A learn with no free slot gives `res_valid`=1, `res_learn`=1, `res_full`=1, `res_hit`=0 and `res_index`=0, and writes nothing.
- R11: If `lk_req` and `learn_req` are both high, only the search runs. A learn in the same cycle as a slot write is dropped: it gives no result and writes nothing.
- R12: In a cycle whose result slot holds no request, `res_valid`, `res_hit`, `res_multi`, `res_learn`, `res_full` and `res_index` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_wr_en | input | 1 | Slot write strobe |
| ent_wr_idx | input | IDX_W | Slot number to write |
| ent_wr_data | input | WIDTH | Data word for the slot |
| ent_wr_dcare | input | WIDTH | Don't-care word for the slot (1 = ignore bit) |
| ent_wr_used | input | 1 | Occupied flag written with the slot |
| gm_wr_en | input | 1 | Global register write strobe |
| gm_wr_sel | input | GSEL_W | Global register number to write |
| gm_wr_dcare | input | WIDTH | Global don't-care word (1 = ignore bit) |
| cmp_wr_en | input | 1 | Comparand register write strobe |
| cmp_wr_data | input | WIDTH | Comparand value |
| lk_req | input | 1 | Search request |
| lk_key | input | WIDTH | Search key |
| lk_gsel | input | GSEL_W | Global register used by the search |
| learn_req | input | 1 | Learn request |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | Match found, or learn placed |
| res_multi | output | 1 | Two or more slots matched |
| res_learn | output | 1 | Result belongs to a learn |
| res_full | output | 1 | Learn found no free slot |
| res_index | output | IDX_W | Winning or learned slot number |

## Verification
The hardest state to reach is a completely full table, because only a long series of learns or writes fills every slot before a learn reports full. The stimulus does this with a directed run of learns that packs the table, then continues learning past the last free slot. Random traffic then mixes slot writes that clear the occupied flag, so free holes open at random positions and learn placement and priority are checked against them. Data words are drawn from a small pool, which makes multiple matches frequent under the random searches.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_LOOKUP = 2'd1,
        OP_LEARN  = 2'd2
    } tcam_op_e;
endpackage

// File: rtl/tcam_prio_enc.sv
// Lowest set bit wins; reports whether any bit is set.
module tcam_prio_enc #(
    parameter int N = 64,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/tcam_compare.sv
// Parallel ternary compare of one key against every slot.
module tcam_compare #(
    parameter int ENTRIES = 64,
    parameter int WIDTH   = 72
) (
    input  logic [WIDTH-1:0]                key,
    input  logic [WIDTH-1:0]                gdc,
    input  logic [ENTRIES-1:0][WIDTH-1:0]   data,
    input  logic [ENTRIES-1:0][WIDTH-1:0]   dcare,
    input  logic [ENTRIES-1:0]              used,
    output logic [ENTRIES-1:0]              hits
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic [WIDTH-1:0] diff;
        assign diff    = (key ^ data[g]) & ~(dcare[g] | gdc);
        assign hits[g] = used[g] && (diff == '0);
    end
endmodule

// File: rtl/tcam_entry_store.sv
// Slot storage: data, don't-care and occupied flag per slot.
module tcam_entry_store #(
    parameter int ENTRIES = 64,
    parameter int WIDTH   = 72,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [WIDTH-1:0]               wr_data,
    input  logic [WIDTH-1:0]               wr_dcare,
    input  logic                           wr_used,
    input  logic                           lrn_en,
    input  logic [IDX_W-1:0]               lrn_idx,
    input  logic [WIDTH-1:0]               lrn_data,
    output logic [ENTRIES-1:0][WIDTH-1:0]  data,
    output logic [ENTRIES-1:0][WIDTH-1:0]  dcare,
    output logic [ENTRIES-1:0]             used
);
    typedef struct packed {
        logic [ENTRIES-1:0][WIDTH-1:0] data;
        logic [ENTRIES-1:0][WIDTH-1:0] dcare;
        logic [ENTRIES-1:0]            used;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.data[wr_idx]  = wr_data;
            st_d.dcare[wr_idx] = wr_dcare;
            st_d.used[wr_idx]  = wr_used;
        end else if (lrn_en) begin
            st_d.data[lrn_idx]  = lrn_data;
            st_d.dcare[lrn_idx] = '0;
            st_d.used[lrn_idx]  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data  = st_q.data;
    assign dcare = st_q.dcare;
    assign used  = st_q.used;
endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup
    import tcam_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int WIDTH   = 72,
    parameter int GMASKS  = 4,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int GSEL_W = $clog2(GMASKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ent_wr_en,
    input  logic [IDX_W-1:0]  ent_wr_idx,
    input  logic [WIDTH-1:0]  ent_wr_data,
    input  logic [WIDTH-1:0]  ent_wr_dcare,
    input  logic              ent_wr_used,
    input  logic              gm_wr_en,
    input  logic [GSEL_W-1:0] gm_wr_sel,
    input  logic [WIDTH-1:0]  gm_wr_dcare,
    input  logic              cmp_wr_en,
    input  logic [WIDTH-1:0]  cmp_wr_data,
    input  logic              lk_req,
    input  logic [WIDTH-1:0]  lk_key,
    input  logic [GSEL_W-1:0] lk_gsel,
    input  logic              learn_req,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_multi,
    output logic              res_learn,
    output logic              res_full,
    output logic [IDX_W-1:0]  res_index
);
    typedef struct packed {
        logic               vld;
        tcam_op_e           op;
        logic [ENTRIES-1:0] hits;
        logic [IDX_W-1:0]   lidx;
        logic               lfull;
    } s1_t;

    typedef struct packed {
        logic             vld;
        logic             hit;
        logic             multi;
        logic             learn;
        logic             full;
        logic [IDX_W-1:0] idx;
    } s2_t;

    typedef struct packed {
        logic [GMASKS-1:0][WIDTH-1:0] gdc;
        logic [WIDTH-1:0]             cmp;
        s1_t                          s1;
        s2_t                          s2;
    } state_t;

    state_t st_d, st_q;

    logic [ENTRIES-1:0][WIDTH-1:0] slot_data;
    logic [ENTRIES-1:0][WIDTH-1:0] slot_dcare;
    logic [ENTRIES-1:0]            slot_used;
    logic [ENTRIES-1:0]            hit_vec;
    logic [WIDTH-1:0]              gdc_sel;
    logic [IDX_W-1:0]              free_idx;
    logic                          free_any;
    logic [IDX_W-1:0]              win_idx;
    logic                          win_any;
    logic                          do_lookup;
    logic                          do_learn;
    logic                          lrn_en;

    // Request arbitration: search beats learn, slot write beats learn.
    assign do_lookup = lk_req;
    assign do_learn  = learn_req && !lk_req && !ent_wr_en;
    assign lrn_en    = do_learn && free_any;
    assign gdc_sel   = st_q.gdc[lk_gsel];

    tcam_entry_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ent_wr_en),
        .wr_idx   (ent_wr_idx),
        .wr_data  (ent_wr_data),
        .wr_dcare (ent_wr_dcare),
        .wr_used  (ent_wr_used),
        .lrn_en   (lrn_en),
        .lrn_idx  (free_idx),
        .lrn_data (st_q.cmp),
        .data     (slot_data),
        .dcare    (slot_dcare),
        .used     (slot_used)
    );

    tcam_compare #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_cmp (
        .key   (lk_key),
        .gdc   (gdc_sel),
        .data  (slot_data),
        .dcare (slot_dcare),
        .used  (slot_used),
        .hits  (hit_vec)
    );

    // Lowest free slot for learn.
    tcam_prio_enc #(.N(ENTRIES)) u_free (
        .vec (~slot_used),
        .idx (free_idx),
        .any (free_any)
    );

    // Lowest matching slot for the registered search.
    tcam_prio_enc #(.N(ENTRIES)) u_win (
        .vec (st_q.s1.hits),
        .idx (win_idx),
        .any (win_any)
    );

    always_comb begin
        st_d = st_q;

        if (gm_wr_en)  st_d.gdc[gm_wr_sel] = gm_wr_dcare;
        if (cmp_wr_en) st_d.cmp = cmp_wr_data;

        // Stage 1: capture compare vector or learn placement.
        st_d.s1.vld   = do_lookup || do_learn;
        st_d.s1.op    = do_lookup ? OP_LOOKUP : (do_learn ? OP_LEARN : OP_IDLE);
        st_d.s1.hits  = do_lookup ? hit_vec : '0;
        st_d.s1.lidx  = free_any ? free_idx : '0;
        st_d.s1.lfull = !free_any;

        // Stage 2: encode result.
        st_d.s2 = '0;
        if (st_q.s1.vld) begin
            st_d.s2.vld = 1'b1;
            if (st_q.s1.op == OP_LEARN) begin
                st_d.s2.learn = 1'b1;
                st_d.s2.full  = st_q.s1.lfull;
                st_d.s2.hit   = !st_q.s1.lfull;
                st_d.s2.idx   = st_q.s1.lfull ? '0 : st_q.s1.lidx;
            end else begin
                st_d.s2.hit   = win_any;
                st_d.s2.multi = |(st_q.s1.hits & (st_q.s1.hits - 1'b1));
                st_d.s2.idx   = win_idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.s2.vld;
    assign res_hit   = st_q.s2.hit;
    assign res_multi = st_q.s2.multi;
    assign res_learn = st_q.s2.learn;
    assign res_full  = st_q.s2.full;
    assign res_index = st_q.s2.idx;
endmodule

// File: rtl/tcam_lookup_chk.sv
module tcam_lookup_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_req,
    input logic             learn_req,
    input logic             ent_wr_en,
    input logic             res_valid,
    input logic             res_hit,
    input logic             res_multi,
    input logic             res_learn,
    input logic             res_full,
    input logic [IDX_W-1:0] res_index
);
    logic req_taken;
    assign req_taken = lk_req || (learn_req && !ent_wr_en);

    a_r7_result_after_two: assert property (@(posedge clk) disable iff (!rst_n)
        req_taken |=> ##1 res_valid);

    a_r12_no_request_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        !req_taken |=> ##1 !res_valid);

    a_r11_search_beats_learn: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> ##1 !res_learn);

    a_r5_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> res_valid);

    a_r6_multi_only_on_search_hit: assert property (@(posedge clk) disable iff (!rst_n)
        res_multi |-> (res_hit && !res_learn));

    a_r10_full_is_learn_miss: assert property (@(posedge clk) disable iff (!rst_n)
        res_full |-> (res_learn && !res_hit && res_index == '0));

    a_r5_miss_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit && !res_learn) |-> res_index == '0);

    a_r12_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_hit && !res_multi && !res_learn && !res_full && res_index == '0));
endmodule

bind tcam_lookup tcam_lookup_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_req    (lk_req),
    .learn_req (learn_req),
    .ent_wr_en (ent_wr_en),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_multi (res_multi),
    .res_learn (res_learn),
    .res_full  (res_full),
    .res_index (res_index)
);

// File: tb/tcam_lookup_test.sv
module tcam_lookup_test;
    localparam int N  = 64;
    localparam int W  = 72;
    localparam int G  = 4;
    localparam int IW = 6;
    localparam int GW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ent_wr_en = 1'b0;
    logic [IW-1:0] ent_wr_idx = '0;
    logic [W-1:0]  ent_wr_data = '0;
    logic [W-1:0]  ent_wr_dcare = '0;
    logic          ent_wr_used = 1'b0;
    logic          gm_wr_en = 1'b0;
    logic [GW-1:0] gm_wr_sel = '0;
    logic [W-1:0]  gm_wr_dcare = '0;
    logic          cmp_wr_en = 1'b0;
    logic [W-1:0]  cmp_wr_data = '0;
    logic          lk_req = 1'b0;
    logic [W-1:0]  lk_key = '0;
    logic [GW-1:0] lk_gsel = '0;
    logic          learn_req = 1'b0;
    logic          res_valid, res_hit, res_multi, res_learn, res_full;
    logic [IW-1:0] res_index;

    always #5 clk = ~clk;

    tcam_lookup uut (
        .clk(clk), .rst_n(rst_n),
        .ent_wr_en(ent_wr_en), .ent_wr_idx(ent_wr_idx), .ent_wr_data(ent_wr_data),
        .ent_wr_dcare(ent_wr_dcare), .ent_wr_used(ent_wr_used),
        .gm_wr_en(gm_wr_en), .gm_wr_sel(gm_wr_sel), .gm_wr_dcare(gm_wr_dcare),
        .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
        .lk_req(lk_req), .lk_key(lk_key), .lk_gsel(lk_gsel), .learn_req(learn_req),
        .res_valid(res_valid), .res_hit(res_hit), .res_multi(res_multi),
        .res_learn(res_learn), .res_full(res_full), .res_index(res_index)
    );

    // Reference model
    logic [W-1:0] m_data [N];
    logic [W-1:0] m_dc   [N];
    bit           m_used [N];
    logic [W-1:0] m_gdc  [G];
    logic [W-1:0] m_cmp;
    logic [W-1:0] pool   [4];

    typedef struct {
        bit    vld, hit, multi, learn, full;
        int    idx;
        string tag;
    } exp_t;

    exp_t pipe0, pipe1;
    int n_tests = 0;
    int n_fail  = 0;

    function automatic exp_t idle_rec(string tag);
        exp_t e;
        e.vld = 0; e.hit = 0; e.multi = 0; e.learn = 0; e.full = 0; e.idx = 0; e.tag = tag;
        return e;
    endfunction

    function automatic logic [W-1:0] rand_w();
        logic [95:0] t;
        t = {$urandom(), $urandom(), $urandom()};
        return t[W-1:0];
    endfunction

    function automatic exp_t model_search(logic [W-1:0] key, int gs, string tag);
        exp_t e;
        int cnt;
        e = idle_rec(tag);
        e.vld = 1;
        cnt = 0;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_used[i] && (((key ^ m_data[i]) & ~(m_dc[i] | m_gdc[gs])) == '0)) begin
                cnt++;
                e.idx = i;
            end
        end
        e.hit   = (cnt > 0);
        e.multi = (cnt > 1);
        if (cnt == 0) e.idx = 0;
        if (tag == "") e.tag = (cnt > 1) ? "R6" : (cnt == 1 ? "R4" : "R5");
        return e;
    endfunction

    task automatic check_out(exp_t e);
        n_tests++;
        if (res_valid !== e.vld || res_hit !== e.hit || res_multi !== e.multi ||
            res_learn !== e.learn || res_full !== e.full || res_index !== IW'(e.idx)) begin
            n_fail++;
            $display("FAIL %s: got v%0b h%0b m%0b l%0b f%0b i%0d, expected v%0b h%0b m%0b l%0b f%0b i%0d",
                     e.tag, res_valid, res_hit, res_multi, res_learn, res_full, res_index,
                     e.vld, e.hit, e.multi, e.learn, e.full, e.idx);
        end
    endtask

    // One cycle: check the result from two requests ago, then drive a new one.
    task automatic step(bit wr, int widx, logic [W-1:0] wd, logic [W-1:0] wdc, bit wu,
                        bit gw, int gsel, logic [W-1:0] gdc,
                        bit cw, logic [W-1:0] cd,
                        bit lk, logic [W-1:0] key, int gs,
                        bit ln, string tag);
        exp_t e;
        int   f;
        @(negedge clk);
        check_out(pipe1);
        pipe1 = pipe0;

        ent_wr_en = wr; ent_wr_idx = IW'(widx); ent_wr_data = wd; ent_wr_dcare = wdc; ent_wr_used = wu;
        gm_wr_en = gw; gm_wr_sel = GW'(gsel); gm_wr_dcare = gdc;
        cmp_wr_en = cw; cmp_wr_data = cd;
        lk_req = lk; lk_key = key; lk_gsel = GW'(gs);
        learn_req = ln;

        f = -1;
        if (lk) begin
            e = model_search(key, gs, tag);
        end else if (ln && !wr) begin
            e = idle_rec(tag);
            e.vld = 1; e.learn = 1;
            for (int i = N - 1; i >= 0; i--) if (!m_used[i]) f = i;
            if (f < 0) begin
                e.full = 1;
                if (tag == "") e.tag = "R10";
            end else begin
                e.hit = 1; e.idx = f;
                if (tag == "") e.tag = "R9";
            end
        end else begin
            e = idle_rec(tag == "" ? "R12" : tag);
        end
        pipe0 = e;

        if (wr) begin
            m_data[widx] = wd; m_dc[widx] = wdc; m_used[widx] = wu;
        end else if (!lk && ln && f >= 0) begin
            m_data[f] = m_cmp; m_dc[f] = '0; m_used[f] = 1;
        end
        if (gw) m_gdc[gsel] = gdc;
        if (cw) m_cmp = cd;
    endtask

    task automatic idle(string tag);
        step(0, 0, '0, '0, 0, 0, 0, '0, 0, '0, 0, '0, 0, 0, tag);
    endtask
    task automatic wr_slot(int idx, logic [W-1:0] d, logic [W-1:0] dc, bit u);
        step(1, idx, d, dc, u, 0, 0, '0, 0, '0, 0, '0, 0, 0, "");
    endtask
    task automatic wr_gm(int sel, logic [W-1:0] dc);
        step(0, 0, '0, '0, 0, 1, sel, dc, 0, '0, 0, '0, 0, 0, "");
    endtask
    task automatic wr_cmp(logic [W-1:0] d);
        step(0, 0, '0, '0, 0, 0, 0, '0, 1, d, 0, '0, 0, 0, "");
    endtask
    task automatic search(logic [W-1:0] key, int gs, string tag);
        step(0, 0, '0, '0, 0, 0, 0, '0, 0, '0, 1, key, gs, 0, tag);
    endtask
    task automatic learn(string tag);
        step(0, 0, '0, '0, 0, 0, 0, '0, 0, '0, 0, '0, 0, 1, tag);
    endtask

    initial begin
        #2_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] ka, kb;
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) begin m_data[i] = '0; m_dc[i] = '0; m_used[i] = 0; end
        for (int i = 0; i < G; i++) m_gdc[i] = '0;
        m_cmp = '0;
        pipe0 = idle_rec("R1");
        pipe1 = idle_rec("R1");

        // R1: outputs quiet during reset
        repeat (3) @(negedge clk);
        check_out(idle_rec("R1"));
        rst_n = 1'b1;

        // R1: empty table misses
        search('0, 0, "R1");
        idle("R1");
        idle("R1");

        ka = rand_w();
        kb = rand_w();

        // R8: write then search in the next cycle
        wr_slot(5, ka, '0, 1);
        search(ka, 0, "R8");
        // R2: slot with low 8 bits don't-care
        wr_slot(9, ka, {{(W-8){1'b0}}, 8'hFF}, 1);
        search(ka ^ 72'h3, 0, "R2");
        search(ka ^ 72'h100, 0, "R2");
        // R4/R6: two slots match, lowest wins
        search(ka, 0, "R6");
        // R3: global register 2 ignores low 16 bits
        wr_gm(2, {{(W-16){1'b0}}, 16'hFFFF});
        search(ka ^ 72'h100, 2, "R3");
        search(ka ^ 72'h100, 0, "R3");
        search(ka ^ 72'h100, 1, "R3");
        // R7: back-to-back searches give results in order
        search(ka, 0, "R7");
        search(ka ^ 72'h1, 0, "R7");
        search(kb, 0, "R7");
        // R8: clearing the occupied flag removes slot 5
        wr_slot(5, ka, '0, 0);
        search(ka, 0, "R8");
        // R9: learn into slot 0, found by the next search
        wr_cmp(kb);
        learn("R9");
        search(kb, 0, "R9");
        // R11: learn with slot write is dropped
        step(1, 40, ka ^ 72'h55, '0, 1, 0, 0, '0, 0, '0, 0, '0, 0, 1, "R11");
        search(kb, 0, "R11");
        // R11: search beats learn
        step(0, 0, '0, '0, 0, 0, 0, '0, 0, '0, 1, ka, 0, 1, "R11");
        search(kb, 0, "R11");
        // R9/R10: fill the table, then learn past full
        for (int k = 0; k < N; k++) learn("");
        learn("R10");
        learn("R10");
        search(kb, 0, "R6");
        search(ka ^ 72'h55, 0, "R10");
        idle("R12");
        idle("R12");

        // Random traffic
        for (int i = 0; i < 4; i++) pool[i] = rand_w();
        for (int n = 0; n < 600; n++) begin
            int r, s;
            logic [W-1:0] sparse;
            r = $urandom_range(0, 11);
            sparse = rand_w() & rand_w() & rand_w();
            if (r <= 2) begin
                wr_slot($urandom_range(0, N - 1), pool[$urandom_range(0, 3)] ^ (sparse & rand_w() & rand_w()),
                        sparse, ($urandom_range(0, 3) != 0));
            end else if (r == 3) begin
                wr_gm($urandom_range(0, G - 1), rand_w() & rand_w() & rand_w() & rand_w());
            end else if (r == 4) begin
                wr_cmp(pool[$urandom_range(0, 3)]);
            end else if (r == 5) begin
                learn("");
            end else if (r == 6) begin
                idle("");
            end else begin
                s = $urandom_range(0, N - 1);
                step(0, 0, '0, '0, 0, 0, 0, '0, 0, '0, 1,
                     m_data[s] ^ (m_dc[s] & rand_w()), $urandom_range(0, G - 1),
                     ($urandom_range(0, 7) == 0), "");
            end
        end
        idle("R12");
        idle("R12");
        idle("R12");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule